// File: doc/BRIEF.md
# Embedded-clock serial link transmitter

This block turns a stream of 24-bit payload words into a serial bit stream with the clock folded into it. It runs on the serial bit clock. One pixel period is 28 bit clocks, and in each of them one word becomes a 28-bit frame. The frame opens with a high clock bit and closes with a low one, so the receiver can recover the pixel clock from the rising edge between frames. Two balance-control bits tell the receiver whether the payload field was sent inverted. The block inverts the field whenever that pulls the running disparity of the stream back toward zero. This keeps the line free of DC drift and lets it be AC coupled.

Beside the serial bit, the block produces a driver output-enable and a one-bit pre-emphasis request for the analog line driver. The driver is enabled only when three conditions hold: the block is awake (not in power-down), the data-enable input is high, and the synchronised lock input is high. In power-down the lock is dropped and must be taken again. A built-in test mode replaces the payload with a PRBS-7 sequence so that a far-end checker can measure the link's bit-error rate.

Top module: `emb_link_tx`

## Requirements
- R1: While the link runs, `frameTick` is high for exactly one cycle in every 28. `payloadIn` is sampled at the rising edge that ends the tick cycle.
- R2: A frame is sent first bit first in this order: position 0 is 1 (clock high); positions 1 to 24 carry payload bits 0 to 23 (possibly inverted); position 25 is the inversion flag; position 26 is its complement; position 27 is 0 (clock low). Bit position k of a frame appears on `serOut` in the (k+1)-th cycle after the sampling edge.
- R3: Running disparity is the sum, over the frames sent since the link started, of ones minus zeros in the sent payload field. The field is inverted exactly when the running disparity and the word's own disparity are both non-zero and have the same sign. The running disparity restarts at 0 whenever the link stops, and its magnitude never exceeds 24.
- R4: `lockAsync` passes through a two-flop synchroniser. After it rises, the first `frameTick` appears after the second rising edge.
- R5: `drvEn` is high only while the link is locked, `awake` is high and `dataEnable` is high. It follows these inputs one clock later. `dataEnable` low does not stop the frame sequence.
- R6: While `awake` is low, the lock is cleared and the frame position returns to the start. `drvEn` is low from the next edge on. When `awake` returns, the lock must pass the synchroniser again before frames resume.
- R7: While `drvEn` is low, `serOut` and `preEmph` are 0.
- R8: In a driven bit time, `preEmph` is 1 exactly when that bit differs from the previously driven bit. The first driven bit after an undriven period is compared with 0.
- R9: While `bistOn` is high, `payloadIn` is ignored and the payload comes from a PRBS-7 generator (x^7+x^6+1) instead. Its 7-bit state s steps by n = s[6]^s[5], s = {s[5:0], n}, and payload bit i is the i-th n produced. The generator takes 24 steps per frame and is reloaded with all ones while `bistOn` is low.
- R10: During reset, `serOut`, `drvEn`, `preEmph` and `frameTick` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock (28 per pixel period) |
| rstN | input | 1 | Asynchronous active-low reset |
| payloadIn | input | 24 | Payload word, sampled at the end of the tick cycle |
| bistOn | input | 1 | Test mode: send PRBS-7 instead of the payload |
| lockAsync | input | 1 | Asynchronous lock indication from the clock source |
| awake | input | 1 | High = operating, low = power-down |
| dataEnable | input | 1 | Driver enable request |
| serOut | output | 1 | Serial bit to the line driver |
| drvEn | output | 1 | Line driver output-enable (low = tri-state) |
| preEmph | output | 1 | Pre-emphasis request for the current bit time |
| frameTick | output | 1 | High in the cycle whose ending edge samples a payload word |

## Verification
Each result has a fixed latency:
- `frameTick` is combinational from state, so it is valid during the cycle after the edge that moved the state.
- `serOut`, `drvEn` and `preEmph` are registered one edge after the bit they carry is selected.
- The first tick trails a lock rise by two edges.

A behavioural reference model in the bench advances at every rising edge, using only the input values held since the previous falling edge. The bench compares all four outputs 1 ns after each rising edge. Timed checks on lock and wake-up wait a counted number of rising edges before sampling.

// File: rtl/emb_tx_pkg.sv
package emb_tx_pkg;
  // Strobes from control to datapath, valid in the current bit time
  typedef struct packed {
    logic run;    // locked and awake: frame sequence advancing
    logic load;   // first bit time of a frame: assemble and start sending
    logic drive;  // driver output-enable for this bit time
    logic last;   // final bit time of a frame
  } txCtl_t;
endpackage

// File: rtl/emb_tx_ctrl.sv
module emb_tx_ctrl
  import emb_tx_pkg::*;
#(
  parameter int FRAME_LEN = 28
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   lockAsync,
  input  logic   awake,
  input  logic   dataEnable,
  output txCtl_t ctl,
  output logic   frameTick
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic lockMeta, lockQ;
  logic [IDX_W-1:0] bitIdx;
  logic run;

  // two-flop lock synchroniser; power-down drops the lock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockMeta <= 1'b0;
      lockQ    <= 1'b0;
    end else if (!awake) begin
      lockMeta <= 1'b0;
      lockQ    <= 1'b0;
    end else begin
      lockMeta <= lockAsync;
      lockQ    <= lockMeta;
    end
  end

  assign run = lockQ && awake;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 bitIdx <= '0;
    else if (!run)             bitIdx <= '0;
    else if (bitIdx == LAST_IDX) bitIdx <= '0;
    else                       bitIdx <= bitIdx + 1'b1;
  end

  always_comb begin
    ctl.run   = run;
    ctl.load  = run && (bitIdx == '0);
    ctl.drive = run && dataEnable;
    ctl.last  = run && (bitIdx == LAST_IDX);
  end

  assign frameTick = ctl.load;

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |=> !frameTick);

  assert_pd_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    !awake |=> (bitIdx == '0) && !frameTick);

  assert_tick_after_last_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.last && awake && lockQ |=> (bitIdx == '0));
endmodule

// File: rtl/emb_tx_prbs.sv
module emb_tx_prbs #(
  parameter int         WORD_W = 24,
  parameter logic [6:0] SEED   = 7'h7F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              advance,
  output logic [WORD_W-1:0] word
);
  logic [6:0] state, walk;

  // WORD_W steps of x^7+x^6+1, one output bit per step
  always_comb begin
    walk = state;
    word = '0;
    for (int i = 0; i < WORD_W; i++) begin
      walk    = {walk[5:0], walk[6] ^ walk[5]};
      word[i] = walk[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        state <= SEED;
    else if (!enable) state <= SEED;
    else if (advance) state <= walk;
  end

  assert_lfsr_live_R9: assert property (@(posedge clk) disable iff (!rstN)
    state != 7'd0);

  assert_lfsr_reload_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> state == SEED);
endmodule

// File: rtl/emb_tx_dp.sv
module emb_tx_dp
  import emb_tx_pkg::*;
#(
  parameter int         PAY_W = 24,
  parameter logic [6:0] SEED  = 7'h7F
) (
  input  logic             clk,
  input  logic             rstN,
  input  txCtl_t           ctl,
  input  logic [PAY_W-1:0] payloadIn,
  input  logic             bistOn,
  output logic             serOut,
  output logic             drvEn,
  output logic             preEmph
);
  localparam int FRAME_LEN = PAY_W + 4;
  localparam int ONES_W    = $clog2(PAY_W + 1);
  localparam int DISP_W    = ONES_W + 2;

  logic [PAY_W-1:0]         prbsWord, pay, body;
  logic [ONES_W-1:0]        ones;
  logic signed [DISP_W-1:0] wordDisp, runDisp, nextDisp;
  logic                     inv;
  logic [FRAME_LEN-1:0]     frame, shReg;
  logic                     bitNow, prevBit;

  emb_tx_prbs #(.WORD_W(PAY_W), .SEED(SEED)) u_prbs (
    .clk    (clk),
    .rstN   (rstN),
    .enable (bistOn),
    .advance(ctl.load),
    .word   (prbsWord)
  );

  assign pay = bistOn ? prbsWord : payloadIn;

  always_comb begin
    ones = '0;
    for (int i = 0; i < PAY_W; i++) ones = ones + ONES_W'(pay[i]);
  end

  always_comb begin
    wordDisp = DISP_W'(2 * int'(ones) - PAY_W);
    inv      = ((runDisp > 0) && (wordDisp > 0)) || ((runDisp < 0) && (wordDisp < 0));
    nextDisp = inv ? (runDisp - wordDisp) : (runDisp + wordDisp);
    body     = inv ? ~pay : pay;
    frame    = {1'b0, ~inv, inv, body, 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         runDisp <= '0;
    else if (!ctl.run) runDisp <= '0;
    else if (ctl.load) runDisp <= nextDisp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         shReg <= '0;
    else if (ctl.load) shReg <= frame >> 1;
    else               shReg <= shReg >> 1;
  end

  assign bitNow = ctl.load ? frame[0] : shReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serOut  <= 1'b0;
      drvEn   <= 1'b0;
      preEmph <= 1'b0;
      prevBit <= 1'b0;
    end else begin
      serOut  <= ctl.drive && bitNow;
      drvEn   <= ctl.drive;
      preEmph <= ctl.drive && (bitNow != prevBit);
      prevBit <= ctl.drive && bitNow;
    end
  end

  assert_disp_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    (int'(runDisp) <= PAY_W) && (int'(runDisp) >= -PAY_W));

  assert_clock_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load && ctl.drive |=> serOut);

  assert_clock_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.last && ctl.drive |=> !serOut);

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !drvEn |-> !serOut && !preEmph);

  assert_pre_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    drvEn && $past(drvEn) |-> preEmph == (serOut != $past(serOut)));
endmodule

// File: rtl/emb_link_tx.sv
module emb_link_tx
  import emb_tx_pkg::*;
#(
  parameter int         PAY_W = 24,
  parameter logic [6:0] SEED  = 7'h7F
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PAY_W-1:0] payloadIn,
  input  logic             bistOn,
  input  logic             lockAsync,
  input  logic             awake,
  input  logic             dataEnable,
  output logic             serOut,
  output logic             drvEn,
  output logic             preEmph,
  output logic             frameTick
);
  localparam int FRAME_LEN = PAY_W + 4;

  txCtl_t ctl;

  emb_tx_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lockAsync (lockAsync),
    .awake     (awake),
    .dataEnable(dataEnable),
    .ctl       (ctl),
    .frameTick (frameTick)
  );

  emb_tx_dp #(.PAY_W(PAY_W), .SEED(SEED)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .payloadIn(payloadIn),
    .bistOn   (bistOn),
    .serOut   (serOut),
    .drvEn    (drvEn),
    .preEmph  (preEmph)
  );

  assert_pd_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !awake |=> !drvEn);

  assert_de_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    !dataEnable |=> !drvEn);
endmodule

// File: tb/tb_emb_link_tx.sv
module tb_emb_link_tx;
  localparam int PW = 24;
  localparam int FL = 28;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PW-1:0] payloadIn = '0;
  logic bistOn = 1'b0, lockAsync = 1'b0, awake = 1'b0, dataEnable = 1'b0;
  logic serOut, drvEn, preEmph, frameTick;

  int checks = 0;
  int failures = 0;
  string curReq = "R10";

  always #2.5 clk = ~clk;

  emb_link_tx dut (
    .clk(clk), .rstN(rstN), .payloadIn(payloadIn), .bistOn(bistOn),
    .lockAsync(lockAsync), .awake(awake), .dataEnable(dataEnable),
    .serOut(serOut), .drvEn(drvEn), .preEmph(preEmph), .frameTick(frameTick)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit mS1, mS2, mPrev;
  int mCnt, mRd;
  logic [6:0] mLfsr = 7'h7F;
  bit frameQ[$];
  bit expSer, expDrv, expPre;

  task automatic buildFrame();
    logic [PW-1:0] p;
    int nOnes, d;
    bit inv;
    nOnes = 0;
    if (bistOn) begin
      for (int i = 0; i < PW; i++) begin
        bit nb;
        nb = mLfsr[6] ^ mLfsr[5];
        mLfsr = {mLfsr[5:0], nb};
        p[i] = nb;
      end
    end else p = payloadIn;
    for (int i = 0; i < PW; i++) nOnes += int'(p[i]);
    d = 2 * nOnes - PW;
    inv = (mRd > 0 && d > 0) || (mRd < 0 && d < 0);
    mRd += inv ? -d : d;
    frameQ.push_back(1'b1);
    for (int i = 0; i < PW; i++) frameQ.push_back(p[i] ^ inv);
    frameQ.push_back(inv);
    frameQ.push_back(!inv);
    frameQ.push_back(1'b0);
  endtask

  always @(posedge clk) begin
    bit run, drive, b;
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mCnt = 0; mRd = 0; mPrev = 0; mLfsr = 7'h7F;
      frameQ.delete();
      expSer = 0; expDrv = 0; expPre = 0;
    end else begin
      run = mS2 && awake;
      drive = run && dataEnable;
      b = 0;
      if (run) begin
        if (mCnt == 0) buildFrame();
        b = frameQ.pop_front();
        mCnt = (mCnt == FL - 1) ? 0 : mCnt + 1;
      end else begin
        frameQ.delete();
        mCnt = 0;
        mRd = 0;
      end
      expSer = drive && b;
      expDrv = drive;
      expPre = drive && (b != mPrev);
      mPrev = drive && b;
      if (!bistOn) mLfsr = 7'h7F;
      if (!awake) begin mS1 = 0; mS2 = 0; end
      else begin mS2 = mS1; mS1 = lockAsync; end
    end
    #1;
    check(curReq, "serOut", serOut, expSer);
    check("R5", "drvEn", drvEn, expDrv);
    check("R8", "preEmph", preEmph, expPre);
    check("R1", "frameTick", frameTick, mS2 && awake && mCnt == 0);
  end

  task automatic sendWord(input logic [PW-1:0] w);
    payloadIn = w;
    do @(negedge clk); while (!frameTick);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int seedV;
    seedV = 32'h1357;
    repeat (3) @(negedge clk);
    check("R10", "serOut in reset", serOut, 0);
    check("R10", "drvEn in reset", drvEn, 0);
    check("R10", "preEmph in reset", preEmph, 0);
    check("R10", "frameTick in reset", frameTick, 0);
    rstN = 1; awake = 1; dataEnable = 1; payloadIn = 24'h000001;
    curReq = "R4";
    @(negedge clk); lockAsync = 1;
    @(posedge clk); #2; check("R4", "tick one edge after lock", frameTick, 0);
    @(posedge clk); #2; check("R4", "tick two edges after lock", frameTick, 1);
    @(negedge clk); @(negedge clk);

    curReq = "R2";
    sendWord(24'hA5A5A5); sendWord(24'h123456); sendWord(24'h000000);
    sendWord(24'h800001); sendWord(24'hFFFFFF);

    curReq = "R3";
    repeat (4) sendWord(24'hFFFFFF);
    repeat (3) sendWord(24'h000000);
    sendWord(24'h0F0F0F); sendWord(24'hFFF000); sendWord(24'h000007);

    curReq = "R8";
    sendWord(24'h555555); sendWord(24'hAAAAAA); sendWord(24'hF0F0F0);

    curReq = "R7";
    @(negedge clk); dataEnable = 0;
    repeat (40) begin
      @(negedge clk);
      check("R7", "serOut while disabled", serOut, 0);
      check("R7", "preEmph while disabled", preEmph, 0);
      check("R5", "drvEn while disabled", drvEn, 0);
    end
    dataEnable = 1;
    curReq = "R5";
    sendWord(24'h3C3C3C); sendWord(24'h00FF00);

    curReq = "R6";
    @(negedge clk); awake = 0;
    @(negedge clk);
    check("R6", "drvEn in power-down", drvEn, 0);
    check("R6", "frameTick in power-down", frameTick, 0);
    repeat (8) @(negedge clk);
    awake = 1;
    @(posedge clk); #2; check("R6", "tick one edge after wake", frameTick, 0);
    @(posedge clk); #2; check("R6", "tick two edges after wake", frameTick, 1);
    @(negedge clk); @(negedge clk);
    sendWord(24'hC0FFEE);

    curReq = "R9";
    bistOn = 1;
    repeat (6) begin
      seedV = seedV * 1103515245 + 12345;
      sendWord(PW'(seedV));
    end
    bistOn = 0;
    curReq = "R2";
    sendWord(24'h0000FF);
    repeat (30) @(negedge clk);
    summary();
    $finish;
  end
endmodule